// File: doc/BRIEF.md
# I2C Master SCL Clock Generator

This block derives the serial clock of an I2C master from the system clock. A 12-bit divide value N is loaded through two byte-wide configuration writes: a control byte carries the low seven bits of N together with a speed-mode bit, and an extension byte carries the upper five bits. The speed mode picks one of two affine period laws, so the SCL period is not a power-of-two division. Values of N below 2 are treated as 2.

The generator runs a low phase and then a high phase, and it releases SCL for the high phase. It gives a one-cycle strobe when each phase starts, and a mid-phase tick that a byte engine uses to drive SDA in the low phase and to sample SDA in the high phase. The high phase only counts down while the bus line reads high, so a slave that holds SCL low stretches the clock. New divider settings are taken only at the start of a low phase. A three-bit input-frequency-range code is stored and read back for other logic. It does not change the timing.

Top module: `scl_clkgen`

## Requirements
- R1: A control write stores the full byte. Bits [6:0] become divider bits [6:0] and bit 7 selects fast mode (1) or standard mode (0). The control readback returns the stored byte and resets to 0x00.
- R2: An extension write stores bits [4:0] as divider bits [11:7]. The extension readback returns those five bits, with bits [7:5] always zero, and it resets to 0x00.
- R3: In standard mode an unstretched SCL period is 2N+7 system clocks: N+4 low and N+3 high.
- R4: In fast mode an unstretched SCL period is 3N+9 system clocks: 2N+6 low and N+3 high.
- R5: A divider value of 0 or 1 gives the same timing as a value of 2.
- R6: The high phase is extended by one clock for every clock edge at which `scl_in` reads low during that phase.
- R7: Divider and mode changes written during a period do not change that period. They take effect at the next low phase.
- R8: While `enable` is low (and after reset), `scl_out` is 1 and no strobe or tick is produced. When enable is raised, the first low phase starts at the next clock edge.
- R9: An address-config write stores bits [7:5] as the frequency-range code. The code resets to 3'b010, reads back on `frange`, and has no effect on SCL timing.
- R10: `low_strobe` is high only in the first cycle of each low phase, and `high_strobe` only in the first cycle of each high phase. `qtick` pulses once per phase: in the low phase on cycle L-1-floor(L/2) (counting from 0), and in the high phase on the cycle where the count of non-stretched high cycles equals H-1-floor(H/2) with `scl_in` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Runs the generator when high |
| ctl_wr | input | 1 | Write strobe for the control byte |
| ctl_wdata | input | 8 | Control byte: divider [6:0], fast-mode bit 7 |
| ext_wr | input | 1 | Write strobe for the extension byte |
| ext_wdata | input | 8 | Extension byte: divider [11:7] in bits [4:0] |
| addr2_wr | input | 1 | Write strobe for the address-config byte |
| addr2_wdata | input | 8 | Address-config byte: frequency range in bits [7:5] |
| scl_in | input | 1 | Sampled level of the SCL line |
| ctl_rdata | output | 8 | Control byte readback |
| ext_rdata | output | 8 | Extension byte readback |
| frange | output | 3 | Stored frequency-range code |
| scl_out | output | 1 | SCL drive: 0 pulls low, 1 releases |
| low_strobe | output | 1 | First cycle of a low phase |
| high_strobe | output | 1 | First cycle of a high phase |
| qtick | output | 1 | Mid-phase tick for SDA drive and sample |

## Verification
On every cycle the assertions check four things: the two phase strobes are never high together, a low phase always hands over to a high phase with its strobe, a held-low SCL freezes the high-phase count, and disabling releases SCL at once. They also check that latched phase lengths change only at a low-phase start and never fall below the clamped minimum. Only the bench scenarios can show that the exact phase lengths follow the 2N+7 and 3N+9 laws, including divider bits split across the two bytes. The same holds for a mid-period write taking effect one period late, and for the frequency-range code leaving the timing unchanged.

// File: rtl/scl_gen_pkg.sv
// Shared types for the SCL clock generator.
// Assumes: nothing beyond IEEE 1800-2017.
package scl_gen_pkg;

    // Phase of the generated SCL waveform.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_HIGH = 2'd2
    } scl_phase_e;

endpackage

// File: rtl/scl_div_cfg.sv
// Divider configuration bytes and phase-length derivation.
// Holds the control, extension and frequency-range fields. It turns the
// split divider into the low and high phase lengths, in system clocks.
// Assumes: write strobes are single-cycle and synchronous to clk.
module scl_div_cfg #(
    parameter int DIV_W = 12,
    parameter int LO_W  = 7,
    parameter int CNT_W = DIV_W + 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_wr,
    input  logic [7:0]       ctl_wdata,
    input  logic             ext_wr,
    input  logic [7:0]       ext_wdata,
    input  logic             addr2_wr,
    input  logic [7:0]       addr2_wdata,
    output logic [7:0]       ctl_rdata,
    output logic [7:0]       ext_rdata,
    output logic [2:0]       frange,
    output logic [CNT_W-1:0] lo_len,
    output logic [CNT_W-1:0] hi_len
);
    localparam int HI_W = DIV_W - LO_W;
    localparam logic [DIV_W-1:0] MIN_DIV = DIV_W'(2);

    logic [7:0]      ctl_q;
    logic [HI_W-1:0] ext_q;
    logic [2:0]      frange_q;
    logic [DIV_W-1:0] div_raw;
    logic [DIV_W-1:0] div_eff;
    logic            fast_mode;

    // Bits of the write bytes with no function here.
    logic unused_wbits;
    assign unused_wbits = ^{ext_wdata[7:HI_W], addr2_wdata[4:0]};

    // Configuration byte storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q    <= 8'h00;
            ext_q    <= '0;
            frange_q <= 3'b010;
        end else begin
            if (ctl_wr)   ctl_q    <= ctl_wdata;
            if (ext_wr)   ext_q    <= ext_wdata[HI_W-1:0];
            if (addr2_wr) frange_q <= addr2_wdata[7:5];
        end
    end

    // Divider assembly, clamping and phase-length laws.
    always_comb begin
        div_raw   = {ext_q, ctl_q[LO_W-1:0]};
        fast_mode = ctl_q[7];
        div_eff   = (div_raw < MIN_DIV) ? MIN_DIV : div_raw;
        hi_len    = CNT_W'(div_eff) + CNT_W'(3);
        if (fast_mode)
            lo_len = (CNT_W'(div_eff) << 1) + CNT_W'(6);
        else
            lo_len = CNT_W'(div_eff) + CNT_W'(4);
    end

    assign ctl_rdata = ctl_q;
    assign ext_rdata = {{(8-HI_W){1'b0}}, ext_q};
    assign frange    = frange_q;

endmodule

// File: rtl/scl_phase_seq.sv
// SCL phase sequencer.
// Runs the low and high phases from latched lengths and stretches the high
// phase while the line reads low. It produces the phase strobes and the
// mid-phase tick.
// Assumes: lo_len and hi_len are at least 2; scl_in is already synchronised.
module scl_phase_seq
    import scl_gen_pkg::*;
#(
    parameter int CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             scl_in,
    input  logic [CNT_W-1:0] lo_len,
    input  logic [CNT_W-1:0] hi_len,
    output logic             scl_out,
    output logic             low_strobe,
    output logic             high_strobe,
    output logic             qtick
);
    scl_phase_e       phase;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] lat_lo;
    logic [CNT_W-1:0] lat_hi;

    // Phase state, down-counter and period-boundary reload.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            phase       <= PH_IDLE;
            cnt         <= '0;
            lat_lo      <= '0;
            lat_hi      <= '0;
            low_strobe  <= 1'b0;
            high_strobe <= 1'b0;
        end else begin
            low_strobe  <= 1'b0;
            high_strobe <= 1'b0;
            unique case (phase)
                PH_IDLE: begin
                    phase      <= PH_LOW;
                    lat_lo     <= lo_len;
                    lat_hi     <= hi_len;
                    cnt        <= lo_len - CNT_W'(1);
                    low_strobe <= 1'b1;
                end
                PH_LOW: begin
                    if (cnt == '0) begin
                        phase       <= PH_HIGH;
                        cnt         <= lat_hi - CNT_W'(1);
                        high_strobe <= 1'b1;
                    end else begin
                        cnt <= cnt - CNT_W'(1);
                    end
                end
                PH_HIGH: begin
                    if (scl_in) begin
                        if (cnt == '0) begin
                            phase      <= PH_LOW;
                            lat_lo     <= lo_len;
                            lat_hi     <= hi_len;
                            cnt        <= lo_len - CNT_W'(1);
                            low_strobe <= 1'b1;
                        end else begin
                            cnt <= cnt - CNT_W'(1);
                        end
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // Line drive and mid-phase tick.
    always_comb begin
        scl_out = (phase != PH_LOW);
        qtick   = ((phase == PH_LOW) && (cnt == (lat_lo >> 1))) ||
                  ((phase == PH_HIGH) && scl_in && (cnt == (lat_hi >> 1)));
    end

    // Phase strobes are mutually exclusive (R10).
    assert_strobes_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({low_strobe, high_strobe}));

    // A finished low phase hands over to a high phase (R3).
    assert_low_to_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && phase == PH_LOW && cnt == '0) |=> (phase == PH_HIGH && high_strobe));

    // A held-low line freezes the high-phase count (R6).
    assert_stretch_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && phase == PH_HIGH && !scl_in) |=> (phase == PH_HIGH && $stable(cnt)));

    // Latched lengths only change at a low-phase start (R7).
    assert_reload_at_boundary_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!low_strobe && phase != PH_IDLE) |-> ($stable(lat_lo) && $stable(lat_hi)));

    // Latched lengths never fall below the clamped minimum (R5).
    assert_min_length_R5: assert property (@(posedge clk) disable iff (!rst_n)
        low_strobe |-> (lat_lo >= CNT_W'(6) && lat_hi >= CNT_W'(5)));

    // Disabling releases the line and silences the strobes (R8).
    assert_disable_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (scl_out && !low_strobe && !high_strobe && !qtick));

endmodule

// File: rtl/scl_clkgen.sv
// I2C master SCL clock generator, top level.
// Joins the divider configuration to the phase sequencer.
// Assumes: a synchronous active-low reset and scl_in already synchronised
// to clk.
module scl_clkgen #(
    parameter int DIV_W = 12,
    parameter int LO_W  = 7
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable,
    input  logic       ctl_wr,
    input  logic [7:0] ctl_wdata,
    input  logic       ext_wr,
    input  logic [7:0] ext_wdata,
    input  logic       addr2_wr,
    input  logic [7:0] addr2_wdata,
    input  logic       scl_in,
    output logic [7:0] ctl_rdata,
    output logic [7:0] ext_rdata,
    output logic [2:0] frange,
    output logic       scl_out,
    output logic       low_strobe,
    output logic       high_strobe,
    output logic       qtick
);
    localparam int CNT_W = DIV_W + 2;

    logic [CNT_W-1:0] lo_len;
    logic [CNT_W-1:0] hi_len;

    scl_div_cfg #(
        .DIV_W (DIV_W),
        .LO_W  (LO_W),
        .CNT_W (CNT_W)
    ) u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctl_wr      (ctl_wr),
        .ctl_wdata   (ctl_wdata),
        .ext_wr      (ext_wr),
        .ext_wdata   (ext_wdata),
        .addr2_wr    (addr2_wr),
        .addr2_wdata (addr2_wdata),
        .ctl_rdata   (ctl_rdata),
        .ext_rdata   (ext_rdata),
        .frange      (frange),
        .lo_len      (lo_len),
        .hi_len      (hi_len)
    );

    scl_phase_seq #(
        .CNT_W (CNT_W)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (enable),
        .scl_in      (scl_in),
        .lo_len      (lo_len),
        .hi_len      (hi_len),
        .scl_out     (scl_out),
        .low_strobe  (low_strobe),
        .high_strobe (high_strobe),
        .qtick       (qtick)
    );

endmodule

// File: tb/scl_clkgen_test.sv
// Bench for scl_clkgen. A behavioural reference model, built on elapsed-cycle
// counters, is compared on every clock. Directed scenarios measure phase
// lengths.
module scl_clkgen_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic       ctl_wr = 1'b0;
    logic [7:0] ctl_wdata = 8'h00;
    logic       ext_wr = 1'b0;
    logic [7:0] ext_wdata = 8'h00;
    logic       addr2_wr = 1'b0;
    logic [7:0] addr2_wdata = 8'h00;
    logic       hold = 1'b0;
    logic       scl_in;
    logic [7:0] ctl_rdata;
    logic [7:0] ext_rdata;
    logic [2:0] frange;
    logic       scl_out;
    logic       low_strobe;
    logic       high_strobe;
    logic       qtick;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    bit done = 1'b0;

    // Wired-AND line: a slave may hold SCL low.
    assign scl_in = scl_out & ~hold;

    always #10 clk = ~clk;

    scl_clkgen uut (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .ext_wr(ext_wr), .ext_wdata(ext_wdata),
        .addr2_wr(addr2_wr), .addr2_wdata(addr2_wdata),
        .scl_in(scl_in),
        .ctl_rdata(ctl_rdata), .ext_rdata(ext_rdata), .frange(frange),
        .scl_out(scl_out), .low_strobe(low_strobe),
        .high_strobe(high_strobe), .qtick(qtick)
    );

    // ---------------- reference model ----------------
    int   m_ph = 0;          // 0 idle, 1 low, 2 high
    int   m_k = 0;           // elapsed (non-stretched) cycles in phase
    int   m_lo = 0, m_hi = 0;
    bit   m_ls = 0, m_hs = 0;
    int   m_ctl = 0, m_ext = 0, m_fr = 2;

    function automatic int div_of(int c, int e);
        int n;
        n = (e % 32) * 128 + (c % 128);
        return (n < 2) ? 2 : n;
    endfunction

    function automatic int lo_of(int c, int e);
        return (c >= 128) ? 2 * div_of(c, e) + 6 : div_of(c, e) + 4;
    endfunction

    function automatic int hi_of(int c, int e);
        return div_of(c, e) + 3;
    endfunction

    always @(posedge clk) begin
        bit line_hi;
        line_hi = (m_ph != 1) && !hold;
        if (!rst_n) begin
            m_ph = 0; m_k = 0; m_ls = 0; m_hs = 0;
            m_ctl = 0; m_ext = 0; m_fr = 2;
        end else begin
            m_ls = 0; m_hs = 0;
            if (!enable) begin
                m_ph = 0; m_k = 0;
            end else if (m_ph == 0) begin
                m_ph = 1; m_k = 0; m_ls = 1;
                m_lo = lo_of(m_ctl, m_ext); m_hi = hi_of(m_ctl, m_ext);
            end else if (m_ph == 1) begin
                if (m_k == m_lo - 1) begin m_ph = 2; m_k = 0; m_hs = 1; end
                else m_k++;
            end else if (line_hi) begin
                if (m_k == m_hi - 1) begin
                    m_ph = 1; m_k = 0; m_ls = 1;
                    m_lo = lo_of(m_ctl, m_ext); m_hi = hi_of(m_ctl, m_ext);
                end else m_k++;
            end
            if (ctl_wr)   m_ctl = ctl_wdata;
            if (ext_wr)   m_ext = ext_wdata % 32;
            if (addr2_wr) m_fr  = addr2_wdata / 32;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cycles);
        end
    endtask

    // Every-cycle comparison against the model, just after the falling edge.
    always @(negedge clk) begin
        #1;
        cycles++;
        if (rst_n && !done) begin
            bit e_scl, e_q;
            e_scl = (m_ph != 1);
            e_q = (m_ph == 1 && m_k == m_lo - 1 - m_lo / 2) ||
                  (m_ph == 2 && scl_in && m_k == m_hi - 1 - m_hi / 2);
            check(scl_out == e_scl, "R3 scl_out", scl_out, e_scl);
            check(low_strobe == m_ls, "R10 low_strobe", low_strobe, m_ls);
            check(high_strobe == m_hs, "R10 high_strobe", high_strobe, m_hs);
            check(qtick == e_q, "R10 qtick", qtick, e_q);
            check(ctl_rdata == m_ctl[7:0], "R1 ctl_rdata", ctl_rdata, m_ctl);
            check(ext_rdata == m_ext[7:0], "R2 ext_rdata", ext_rdata, m_ext);
            check(frange == m_fr[2:0], "R9 frange", frange, m_fr);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr_ctl(input logic [7:0] d);
        @(negedge clk); ctl_wr = 1'b1; ctl_wdata = d;
        @(negedge clk); ctl_wr = 1'b0;
    endtask

    task automatic wr_ext(input logic [7:0] d);
        @(negedge clk); ext_wr = 1'b1; ext_wdata = d;
        @(negedge clk); ext_wr = 1'b0;
    endtask

    task automatic wr_addr2(input logic [7:0] d);
        @(negedge clk); addr2_wr = 1'b1; addr2_wdata = d;
        @(negedge clk); addr2_wr = 1'b0;
    endtask

    // Measure one full period from a low strobe. It can stretch the high
    // phase and can write the control byte in the first low cycle.
    task automatic measure(input int stretch, input bit do_wr, input logic [7:0] wval,
                           output int lo, output int hi);
        @(negedge clk);
        while (!low_strobe) @(negedge clk);
        if (do_wr) begin ctl_wr = 1'b1; ctl_wdata = wval; end
        lo = 0;
        while (!scl_out) begin
            lo++;
            @(negedge clk);
            ctl_wr = 1'b0;
        end
        hi = 0;
        while (scl_out) begin
            hold = (hi < stretch);
            hi++;
            @(negedge clk);
        end
        hold = 1'b0;
    endtask

    task automatic expect_period(input int lo, input int hi, input int elo, input int ehi,
                                 input string req);
        check(lo == elo, {req, " low length"}, lo, elo);
        check(hi == ehi, {req, " high length"}, hi, ehi);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int lo, hi;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #2;
        // R8/R1/R2/R9 reset state
        check(scl_out == 1'b1, "R8 reset scl_out", scl_out, 1);
        check(ctl_rdata == 8'h00, "R1 reset ctl", ctl_rdata, 0);
        check(ext_rdata == 8'h00, "R2 reset ext", ext_rdata, 0);
        check(frange == 3'b010, "R9 reset frange", frange, 2);

        // R3: standard mode, N=5 -> low 9, high 8
        wr_ctl(8'h05);
        enable = 1'b1;
        measure(0, 1'b0, 8'h00, lo, hi);
        expect_period(lo, hi, 9, 8, "R3 std N=5");

        // R4: fast mode, N=5 -> low 16, high 8
        wr_ctl(8'h85);
        measure(0, 1'b0, 8'h00, lo, hi);
        measure(0, 1'b0, 8'h00, lo, hi);
        expect_period(lo, hi, 16, 8, "R4 fast N=5");

        // R2: split divider, N=131 std -> low 135, high 134; upper ext bits dropped
        wr_ctl(8'h03);
        wr_ext(8'hE1);
        check(ext_rdata == 8'h01, "R2 ext readback", ext_rdata, 1);
        measure(0, 1'b0, 8'h00, lo, hi);
        measure(0, 1'b0, 8'h00, lo, hi);
        expect_period(lo, hi, 135, 134, "R2 split N=131");
        wr_ext(8'h00);

        // R5: N=1 clamps to 2 -> low 6, high 5; N=0 fast -> low 10, high 5
        wr_ctl(8'h01);
        measure(0, 1'b0, 8'h00, lo, hi);
        measure(0, 1'b0, 8'h00, lo, hi);
        expect_period(lo, hi, 6, 5, "R5 clamp std");
        wr_ctl(8'h80);
        measure(0, 1'b0, 8'h00, lo, hi);
        measure(0, 1'b0, 8'h00, lo, hi);
        expect_period(lo, hi, 10, 5, "R5 clamp fast");

        // R6: std N=5, stretch by 7 -> high 15
        wr_ctl(8'h05);
        measure(0, 1'b0, 8'h00, lo, hi);
        measure(7, 1'b0, 8'h00, lo, hi);
        expect_period(lo, hi, 9, 15, "R6 stretch");

        // R7: write N=8 in mid-period; this period 9/8, next 12/11
        measure(0, 1'b1, 8'h08, lo, hi);
        expect_period(lo, hi, 9, 8, "R7 current period");
        measure(0, 1'b0, 8'h00, lo, hi);
        expect_period(lo, hi, 12, 11, "R7 next period");

        // R9: frange write leaves timing unchanged
        wr_addr2(8'hE6);
        check(frange == 3'b111, "R9 frange readback", frange, 7);
        measure(0, 1'b0, 8'h00, lo, hi);
        measure(0, 1'b0, 8'h00, lo, hi);
        expect_period(lo, hi, 12, 11, "R9 timing unchanged");

        // R8: disable mid-low releases the line; re-enable starts a low phase
        @(negedge clk);
        while (!low_strobe) @(negedge clk);
        repeat (3) @(negedge clk);
        enable = 1'b0;
        @(negedge clk); #2;
        check(scl_out == 1'b1, "R8 disabled scl_out", scl_out, 1);
        check(!low_strobe && !high_strobe && !qtick, "R8 disabled strobes",
              {low_strobe, high_strobe, qtick}, 0);
        repeat (4) @(negedge clk);
        check(scl_out == 1'b1, "R8 still released", scl_out, 1);
        enable = 1'b1;
        @(negedge clk); #2;
        check(low_strobe == 1'b1 && scl_out == 1'b0, "R8 restart low",
              {low_strobe, scl_out}, 2);
        measure(0, 1'b0, 8'h00, lo, hi);
        expect_period(lo, hi, 12, 11, "R8 after restart");

        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule